// File: doc/BRIEF.md
# Dual-Port Control Register Bank

A bank of 64-bit control and status registers that two requesters share: a scan-style configuration port and a memory-mapped port. Each port presents a byte address and turns it into a register index. The two ports reach the same storage, but the memory-mapped map is shifted by ten words. Every access moves one whole 64-bit word, so byte order never splits a field.

Besides plain read/write registers, the bank has a fault word and a control word that are reached through extra alias indices. These aliases AND, OR, set or clear bits in place, so firmware can change single bits without a read-modify-write. A base-address register holds a window address and an enable bit. The block drives that window to its outputs and pulses a change strobe whenever the window, or the control word's memory-enable bit, is modified. Only the configuration port may write the base register. Bad accesses of every kind are gathered into one sticky error flag.

Top module: `rb_dualport`

## Requirements
- R1: The configuration port uses index = byte address >> 3. The memory-mapped port uses index = (byte address >> 3) + 0x0A. Address bits [2:0] are ignored. An index of 64 or more is unmapped.
- R2: After reset every register reads zero, except the base register. The base register reads BASE_DEFAULT masked by 0x0003_FFFF_FFF0_0000, with bit 0 set. The error flag is low and the change strobe is low.
- R3: The fault word is at index 0x00 and is fully writable. A write to index 0x01 ANDs the data into it. A write to index 0x02 ORs the data into it.
- R4: The control word is at index 0x0E and is fully writable. A write to index 0x12 sets the bits that are 1 in the data. A write to index 0x13 clears the bits that are 1 in the data.
- R5: The base register is at index 0x0A. It keeps only bits 0x0003_FFFF_FFF0_0000 and the enable bit 0. win_en_o shows bit 0, and win_base_o shows the address bits.
- R6: A memory-mapped write to index 0x0A leaves the base register unchanged and raises the error flag. Memory-mapped reads of index 0x0A are allowed.
- R7: Index 0x0B keeps only bits 0x0003_FFFF_0000_0000. Index 0x1B keeps only bits 0xFFFF_E00F_0000_0000. Indices 0x06, 0x07, 0x0F and 0x14 hold all 64 bits.
- R8: A read of an unmapped index, or of one of the write-only aliases 0x01, 0x02, 0x12 and 0x13, returns all ones. A write to an unmapped index changes nothing. Both cases raise the error flag.
- R9: Read data appears on the port's rdata output one cycle after the request and is held until the next read. It shows register contents from before any write accepted in the same cycle.
- R10: win_chg_o is high for exactly the one cycle after an accepted write that changes the base register or flips control bit 62. No other write raises it.
- R11: The error flag rises the cycle after a bad access and stays high until reset.
- R12: When both ports write in the same cycle, only the configuration write takes effect. The memory-mapped write is dropped and raises the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Configuration port access strobe |
| cfg_we_i | input | 1 | Configuration port write (1) or read (0) |
| cfg_addr_i | input | ADDR_W | Configuration port byte address |
| cfg_wdata_i | input | 64 | Configuration port write data |
| cfg_rdata_o | output | 64 | Configuration port read data |
| mmio_req_i | input | 1 | Memory-mapped port access strobe |
| mmio_we_i | input | 1 | Memory-mapped port write (1) or read (0) |
| mmio_addr_i | input | ADDR_W | Memory-mapped port byte address |
| mmio_wdata_i | input | 64 | Memory-mapped port write data |
| mmio_rdata_o | output | 64 | Memory-mapped port read data |
| win_en_o | output | 1 | Base window enable |
| win_base_o | output | 64 | Base window address bits |
| win_chg_o | output | 1 | One-cycle window or memory-enable change strobe |
| err_o | output | 1 | Sticky invalid-access flag |

## Verification
The assertions check, on every cycle, properties that need no model of the register contents. Once set, the error flag never drops. A memory-mapped write to the base index always raises it. The base window never moves unless the configuration port writes. The change strobe only follows a write. A read of a write-only alias always returns all ones. Only the bench scenarios can show the data itself: the AND, OR, set and clear results, the field masks, the shifted memory-mapped map, read-before-write ordering, and which write survives when both ports write in the same cycle.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int DW = 64;
  localparam int MEM_EN_BIT = 62;

  typedef enum logic [3:0] {
    S_FAULT, S_ACT0, S_ACT1, S_BASE, S_FBASE, S_CTRL, S_SEMR, S_DMAUP, S_OFFS
  } slot_e;
  localparam int NUM_SLOTS = 9;

  typedef enum logic [1:0] {OP_PLAIN, OP_AND, OP_OR, OP_CLR} op_e;

  typedef struct packed {
    logic  rd_ok;
    logic  wr_ok;
    slot_e slot;
    op_e   op;
  } dec_t;

  localparam logic [DW-1:0] BASE_MASK  = 64'h0003_FFFF_FFF0_0001;
  localparam logic [DW-1:0] FBASE_MASK = 64'h0003_FFFF_0000_0000;
  localparam logic [DW-1:0] OFFS_MASK  = 64'hFFFF_E00F_0000_0000;

  function automatic logic [DW-1:0] slot_mask(int s);
    case (s)
      int'(S_BASE):  return BASE_MASK;
      int'(S_FBASE): return FBASE_MASK;
      int'(S_OFFS):  return OFFS_MASK;
      default:       return '1;
    endcase
  endfunction
endpackage

// File: rtl/rb_decode.sv
module rb_decode
  import rb_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int IDX_OFFSET  = 0,
  parameter bit BASE_WR_OK  = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic [2:0] unused_lo;
  assign unused_lo = addr_i[2:0];

  int unsigned idx;
  assign idx = 32'(addr_i[ADDR_W-1:3]) + 32'(IDX_OFFSET);

  always_comb begin
    dec_o = '{rd_ok: 1'b0, wr_ok: 1'b0, slot: S_FAULT, op: OP_PLAIN};
    case (idx)
      32'h00: dec_o = '{1'b1, 1'b1, S_FAULT, OP_PLAIN};
      32'h01: dec_o = '{1'b0, 1'b1, S_FAULT, OP_AND};
      32'h02: dec_o = '{1'b0, 1'b1, S_FAULT, OP_OR};
      32'h06: dec_o = '{1'b1, 1'b1, S_ACT0, OP_PLAIN};
      32'h07: dec_o = '{1'b1, 1'b1, S_ACT1, OP_PLAIN};
      32'h0A: dec_o = '{1'b1, BASE_WR_OK, S_BASE, OP_PLAIN};
      32'h0B: dec_o = '{1'b1, 1'b1, S_FBASE, OP_PLAIN};
      32'h0E: dec_o = '{1'b1, 1'b1, S_CTRL, OP_PLAIN};
      32'h0F: dec_o = '{1'b1, 1'b1, S_SEMR, OP_PLAIN};
      32'h12: dec_o = '{1'b0, 1'b1, S_CTRL, OP_OR};
      32'h13: dec_o = '{1'b0, 1'b1, S_CTRL, OP_CLR};
      32'h14: dec_o = '{1'b1, 1'b1, S_DMAUP, OP_PLAIN};
      32'h1B: dec_o = '{1'b1, 1'b1, S_OFFS, OP_PLAIN};
      default: ;
    endcase
  end
endmodule

// File: rtl/rb_field.sv
module rb_field
  import rb_pkg::*;
#(
  parameter logic [DW-1:0] MASK = '1,
  parameter logic [DW-1:0] RST  = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  op_e           op_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] nxt_o
);
  logic [DW-1:0] raw;

  always_comb begin
    case (op_i)
      OP_AND:  raw = q_o & wdata_i;
      OP_OR:   raw = q_o | wdata_i;
      OP_CLR:  raw = q_o & ~wdata_i;
      default: raw = wdata_i;
    endcase
  end
  assign nxt_o = raw & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST & MASK;
    else if (wr_i) q_o <= nxt_o;
  end
endmodule

// File: rtl/rb_dualport.sv
module rb_dualport
  import rb_pkg::*;
#(
  parameter int          ADDR_W       = 9,
  parameter logic [63:0] BASE_DEFAULT = 64'h0000_0006_0300_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_req_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [63:0]       cfg_wdata_i,
  output logic [63:0]       cfg_rdata_o,
  input  logic              mmio_req_i,
  input  logic              mmio_we_i,
  input  logic [ADDR_W-1:0] mmio_addr_i,
  input  logic [63:0]       mmio_wdata_i,
  output logic [63:0]       mmio_rdata_o,
  output logic              win_en_o,
  output logic [63:0]       win_base_o,
  output logic              win_chg_o
  ,output logic             err_o
);
  localparam logic [DW-1:0] BASE_RST = BASE_DEFAULT | 64'd1;

  dec_t cdec, mdec;

  rb_decode #(.ADDR_W(ADDR_W), .IDX_OFFSET(0), .BASE_WR_OK(1'b1)) u_cdec (
    .addr_i(cfg_addr_i), .dec_o(cdec));
  rb_decode #(.ADDR_W(ADDR_W), .IDX_OFFSET(10), .BASE_WR_OK(1'b0)) u_mdec (
    .addr_i(mmio_addr_i), .dec_o(mdec));

  logic cfg_wr, mmio_wr, cfg_ok, mmio_ok;
  logic cfg_bad, mmio_bad;
  assign cfg_wr  = cfg_req_i & cfg_we_i;
  assign mmio_wr = mmio_req_i & mmio_we_i;
  assign cfg_ok  = cfg_wr & cdec.wr_ok;
  assign mmio_ok = mmio_wr & mdec.wr_ok & ~cfg_wr;  // config port wins
  assign cfg_bad  = cfg_req_i & (cfg_we_i ? ~cdec.wr_ok : ~cdec.rd_ok);
  assign mmio_bad = mmio_req_i & (mmio_we_i ? (~mdec.wr_ok | cfg_wr) : ~mdec.rd_ok);

  logic          w_en;
  slot_e         w_slot;
  op_e           w_op;
  logic [DW-1:0] w_data;
  assign w_en   = cfg_ok | mmio_ok;
  assign w_slot = cfg_ok ? cdec.slot : mdec.slot;
  assign w_op   = cfg_ok ? cdec.op : mdec.op;
  assign w_data = cfg_ok ? cfg_wdata_i : mmio_wdata_i;

  logic [DW-1:0] rq  [NUM_SLOTS];
  logic [DW-1:0] rnx [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    rb_field #(
      .MASK(slot_mask(g)),
      .RST (g == int'(S_BASE) ? BASE_RST : '0)
    ) u_field (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (w_en && (w_slot == slot_e'(g))),
      .op_i   (w_op),
      .wdata_i(w_data),
      .q_o    (rq[g]),
      .nxt_o  (rnx[g])
    );
  end

  logic base_mod, memen_mod;
  assign base_mod  = w_en && (w_slot == S_BASE) && (rnx[S_BASE] != rq[S_BASE]);
  assign memen_mod = w_en && (w_slot == S_CTRL) &&
                     (rnx[S_CTRL][MEM_EN_BIT] != rq[S_CTRL][MEM_EN_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rdata_o  <= '0;
      mmio_rdata_o <= '0;
      win_chg_o    <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      if (cfg_req_i && !cfg_we_i)
        cfg_rdata_o <= cdec.rd_ok ? rq[cdec.slot] : '1;
      if (mmio_req_i && !mmio_we_i)
        mmio_rdata_o <= mdec.rd_ok ? rq[mdec.slot] : '1;
      win_chg_o <= base_mod | memen_mod;
      if (cfg_bad || mmio_bad) err_o <= 1'b1;
    end
  end

  assign win_en_o   = rq[S_BASE][0];
  assign win_base_o = {rq[S_BASE][DW-1:1], 1'b0};
endmodule

// File: rtl/rb_dualport_chk.sv
module rb_dualport_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_req_i,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [63:0]       cfg_rdata_o,
  input logic              mmio_req_i,
  input logic              mmio_we_i,
  input logic [ADDR_W-1:0] mmio_addr_i,
  input logic              win_en_o,
  input logic [63:0]       win_base_o,
  input logic              win_chg_o,
  input logic              err_o
);
  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r6_mmio_base_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmio_req_i && mmio_we_i && mmio_addr_i[ADDR_W-1:3] == '0) |=> err_o);

  a_r5_base_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_req_i && cfg_we_i) |=> ($stable(win_base_o) && $stable(win_en_o)));

  a_r10_chg_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_chg_o |-> $past((cfg_req_i && cfg_we_i) || (mmio_req_i && mmio_we_i)));

  a_r8_alias_reads_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && !cfg_we_i && cfg_addr_i[ADDR_W-1:3] == (ADDR_W-3)'(1))
    |=> cfg_rdata_o == '1);
endmodule

bind rb_dualport rb_dualport_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_rb_dualport.sv
module tb_rb_dualport;
  localparam int          ADDR_W = 9;
  localparam logic [63:0] BASE_D = 64'h0000_0006_0300_0000;
  localparam logic [63:0] ONES   = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_req = 0, cfg_we = 0, mmio_req = 0, mmio_we = 0;
  logic [ADDR_W-1:0] cfg_addr = '0, mmio_addr = '0;
  logic [63:0] cfg_wdata = '0, mmio_wdata = '0;
  logic [63:0] cfg_rdata, mmio_rdata, win_base;
  logic win_en, win_chg, err;

  int n_chk = 0, n_bad = 0;
  logic last_chg;
  logic [63:0] rv;

  always #2 clk = ~clk;

  rb_dualport #(.ADDR_W(ADDR_W), .BASE_DEFAULT(BASE_D)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_req_i(cfg_req), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .mmio_req_i(mmio_req), .mmio_we_i(mmio_we), .mmio_addr_i(mmio_addr),
    .mmio_wdata_i(mmio_wdata), .mmio_rdata_o(mmio_rdata),
    .win_en_o(win_en), .win_base_o(win_base), .win_chg_o(win_chg), .err_o(err));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk); cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_req = 0; cfg_we = 0; last_chg = win_chg;
  endtask

  task automatic mmio_write(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk); mmio_req = 1; mmio_we = 1; mmio_addr = a; mmio_wdata = d;
    @(negedge clk); mmio_req = 0; mmio_we = 0; last_chg = win_chg;
  endtask

  task automatic cfg_read(input logic [ADDR_W-1:0] a, output logic [63:0] d);
    @(negedge clk); cfg_req = 1; cfg_we = 0; cfg_addr = a;
    @(negedge clk); cfg_req = 0; d = cfg_rdata;
  endtask

  task automatic mmio_read(input logic [ADDR_W-1:0] a, output logic [63:0] d);
    @(negedge clk); mmio_req = 1; mmio_we = 0; mmio_addr = a;
    @(negedge clk); mmio_req = 0; d = mmio_rdata;
  endtask

  task automatic t_reset;
    chk("R2 err", {63'd0, err}, 64'd0);
    chk("R2 chg", {63'd0, win_chg}, 64'd0);
    chk("R2 win_en", {63'd0, win_en}, 64'd1);
    chk("R2 win_base", win_base, BASE_D);
    cfg_read(9'h50, rv); chk("R2 base", rv, BASE_D | 64'd1);
    cfg_read(9'h00, rv); chk("R2 fault", rv, 64'd0);
    cfg_read(9'h70, rv); chk("R2 ctrl", rv, 64'd0);
    cfg_read(9'hD8, rv); chk("R2 offset", rv, 64'd0);
  endtask

  task automatic t_plain;
    cfg_write(9'h30, 64'hA5A5_5A5A_0123_4567);
    cfg_read(9'h30, rv); chk("R7 act0", rv, 64'hA5A5_5A5A_0123_4567);
    cfg_write(9'h78, 64'hDEAD_BEEF_CAFE_F00D);
    mmio_read(9'h28, rv); chk("R1 mmio map 0x0F", rv, 64'hDEAD_BEEF_CAFE_F00D);
    mmio_write(9'h2F, 64'h1111_2222_3333_4444);  // low bits ignored
    cfg_read(9'h7D, rv); chk("R1 low addr bits", rv, 64'h1111_2222_3333_4444);
    chk("R10 no chg plain", {63'd0, last_chg}, 64'd0);
  endtask

  task automatic t_fault;
    cfg_write(9'h00, 64'hF0F0_F0F0_F0F0_F0F0);
    cfg_write(9'h08, 64'hFF00_FF00_FF00_FF00);
    cfg_read(9'h00, rv); chk("R3 and", rv, 64'hF000_F000_F000_F000);
    cfg_write(9'h10, 64'h0000_0000_0000_000F);
    cfg_read(9'h00, rv); chk("R3 or", rv, 64'hF000_F000_F000_F00F);
  endtask

  task automatic t_ctrl;
    mmio_write(9'h20, 64'h0000_0000_0000_00FF);
    cfg_write(9'h90, 64'h8000_0000_0000_0000);
    chk("R10 no chg bit63", {63'd0, last_chg}, 64'd0);
    cfg_write(9'h98, 64'h0000_0000_0000_000F);
    cfg_read(9'h70, rv); chk("R4 set/clear", rv, 64'h8000_0000_0000_00F0);
    cfg_write(9'h90, 64'h4000_0000_0000_0000);
    chk("R10 chg mem-en", {63'd0, last_chg}, 64'd1);
    @(negedge clk); chk("R10 chg one cycle", {63'd0, win_chg}, 64'd0);
    cfg_write(9'h90, 64'h4000_0000_0000_0000);
    chk("R10 no chg same bit", {63'd0, last_chg}, 64'd0);
    cfg_write(9'h98, 64'h4000_0000_0000_0000);
    chk("R10 chg mem-en clear", {63'd0, last_chg}, 64'd1);
    chk("R11 no err yet", {63'd0, err}, 64'd0);
  endtask

  task automatic t_base;
    cfg_write(9'h50, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R10 chg base", {63'd0, last_chg}, 64'd1);
    chk("R5 win_en off", {63'd0, win_en}, 64'd0);
    cfg_read(9'h50, rv); chk("R5 base mask", rv, 64'h0003_FFFF_FFF0_0000);
    cfg_write(9'h50, 64'h0000_0001_0000_0001);
    chk("R5 win_base", win_base, 64'h0000_0001_0000_0000);
    chk("R5 win_en on", {63'd0, win_en}, 64'd1);
  endtask

  task automatic t_mmio_base;
    mmio_write(9'h00, 64'h0);
    chk("R6 err", {63'd0, err}, 64'd1);
    chk("R6 no chg", {63'd0, last_chg}, 64'd0);
    mmio_read(9'h00, rv); chk("R6 base kept", rv, 64'h0000_0001_0000_0001);
    chk("R11 sticky", {63'd0, err}, 64'd1);
  endtask

  task automatic t_masks;
    cfg_write(9'h58, ONES);
    cfg_read(9'h58, rv); chk("R7 fbase mask", rv, 64'h0003_FFFF_0000_0000);
    cfg_write(9'hD8, ONES);
    mmio_read(9'h88, rv); chk("R7 offset mask", rv, 64'hFFFF_E00F_0000_0000);
  endtask

  task automatic t_unmapped;
    cfg_read(9'h18, rv); chk("R8 unmapped read", rv, ONES);
    cfg_write(9'h18, 64'h0);
    cfg_read(9'h18, rv); chk("R8 unmapped write dropped", rv, ONES);
    cfg_read(9'h30, rv); chk("R8 neighbour intact", rv, 64'hA5A5_5A5A_0123_4567);
    cfg_read(9'h08, rv); chk("R8 alias read", rv, ONES);
    mmio_read(9'h1F8, rv); chk("R8 mmio beyond map", rv, ONES);
  endtask

  task automatic t_order;
    cfg_write(9'hA0, 64'd1);
    @(negedge clk);
    cfg_req = 1; cfg_we = 0; cfg_addr = 9'hA0;
    mmio_req = 1; mmio_we = 1; mmio_addr = 9'h50; mmio_wdata = 64'd2;
    @(negedge clk); cfg_req = 0; mmio_req = 0; mmio_we = 0;
    chk("R9 read before write", cfg_rdata, 64'd1);
    cfg_read(9'hA0, rv); chk("R9 later read", rv, 64'd2);
    @(negedge clk); chk("R9 rdata held", cfg_rdata, 64'd2);
  endtask

  task automatic t_collide;
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_addr = 9'hA0; cfg_wdata = 64'd3;
    mmio_req = 1; mmio_we = 1; mmio_addr = 9'h50; mmio_wdata = 64'd4;
    @(negedge clk); cfg_req = 0; cfg_we = 0; mmio_req = 0; mmio_we = 0;
    mmio_read(9'h50, rv); chk("R12 cfg wins", rv, 64'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_fault();
    t_ctrl();
    t_base();
    t_mmio_base();
    t_masks();
    t_unmapped();
    t_order();
    t_collide();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule